// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-up

This block is the supervisory timer of a small microcontroller. It counts rising edges of a slow, free-running oscillator whose level arrives asynchronously. The edges pass through a power-of-two postscaler and then into a base counter. When the base counter runs out, the block looks at the core's state. A running core gets a one-cycle device reset request. A sleeping core gets a one-cycle wake-up request instead. Either way, an active-low time-out flag drops.

The block is clocked by an always-on clock, which stays alive while the core clock is gated in sleep. The oscillator level is synchronised into that domain before its edges are counted.

Firmware stops an expiry in two ways. It can issue a clear strobe, or it can issue the sleep-entry strobe. Both zero the base counter and the postscaler count. Neither changes the postscaler ratio, which comes only from configuration inputs.

A configuration enable forces the timer on. While that enable is low, bit 0 of an 8-bit control register turns the timer on or off. That register is reached over a plain write-strobe bus with a registered read value.

Top module: `wdt_sleep_top`

## Requirements
- R1: After reset, `rst_req_o` and `wake_o` are 0, `to_n_o` is 1 and `bus_rdata_o` reads 0x00.
- R2: With the timer enabled, an expiry happens on every (2^`cfg_ps_sel_i`) × TIMEOUT_TICKS-th synchronised rising edge of `osc_i` since the last clear. A select value s means a divide by 2^s, so 0 means 1 and 7 means 128.
- R3: An expiry while `core_asleep_i` is 0 raises `rst_req_o` for exactly one clock and leaves `wake_o` low.
- R4: An expiry while `core_asleep_i` is 1 raises `wake_o` for exactly one clock and leaves `rst_req_o` low.
- R5: `to_n_o` falls to 0 with every expiry. It returns to 1 only on reset or on a `clr_i` strobe.
- R6: A `clr_i` strobe zeroes both the base counter and the postscaler count, so the next expiry needs a full period of edges. The divide ratio is left unchanged.
- R7: A `sleep_i` strobe zeroes the counters just as `clr_i` does, but it does not change `to_n_o`.
- R8: While `cfg_en_i` is 1, the timer runs whatever the value of control bit 0.
- R9: While `cfg_en_i` is 0, control bit 0 enables the timer (1) or disables it (0). A disabled timer never expires, and its counters are held at zero.
- R10: The control register has only bit 0 as storage, written from `bus_wdata_i[0]` when `bus_wr_i` is high. Bits 7 to 1 always read 0 and ignore writes.
- R11: An expiry pulse appears in the third clock cycle after the clock edge that first samples `osc_i` high. That is two synchroniser stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_i | input | 1 | Asynchronous level of the slow oscillator |
| cfg_en_i | input | 1 | Configuration enable; forces the timer on |
| cfg_ps_sel_i | input | 3 | Postscaler select, divide by 2^value |
| clr_i | input | 1 | Clear-watchdog strobe from the core |
| sleep_i | input | 1 | Sleep-entry strobe from the core |
| core_asleep_i | input | 1 | Core is currently in sleep mode |
| bus_wr_i | input | 1 | Control register write strobe |
| bus_wdata_i | input | 8 | Control register write data |
| bus_rdata_o | output | 8 | Control register read value |
| rst_req_o | output | 1 | One-cycle device reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Active-low time-out status |

## Verification
The bench raises `osc_i` just after a falling clock edge and holds it high for two clocks. An expiry pulse is due at the third rising edge after that. The bench therefore samples `rst_req_o` and `wake_o` at the falling edge after the third rising edge. It samples them again one clock later, and there they must be low.

The bench counts edges in the same way to predict the exact edge number, 2^s × TIMEOUT_TICKS, for all eight selects. Strobes and bus writes are driven for one clock between edges. Their effect on `to_n_o` and `bus_rdata_o` is read at the next falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_SEL_W = 3;
  localparam int PS_CNT_W = (1 << PS_SEL_W) - 1;
  localparam int REG_W    = 8;

  typedef enum logic [1:0] {
    EXP_NONE  = 2'd0,
    EXP_RESET = 2'd1,
    EXP_WAKE  = 2'd2
  } exp_kind_e;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_i,
  output logic tick_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= osc_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign tick_o = chain[STAGES-1] & ~last_q;

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                tick_i,
  input  logic [PS_SEL_W-1:0] sel_i,
  output logic                step_o
);
  logic [PS_CNT_W-1:0] cnt_q;
  logic [PS_CNT_W:0]   span;
  logic [PS_CNT_W:0]   span_m1;
  logic [PS_CNT_W-1:0] limit;
  logic                at_limit;

  assign span     = {{PS_CNT_W{1'b0}}, 1'b1} << sel_i;
  assign span_m1  = span - {{PS_CNT_W{1'b0}}, 1'b1};
  assign limit    = span_m1[PS_CNT_W-1:0];
  assign at_limit = (cnt_q >= limit);
  assign step_o   = tick_i & at_limit & ~clear_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_q <= '0;
    else if (tick_i) begin
      if (at_limit) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  p_ps_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
  p_ps_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term  = (cnt_q == TERM);
  assign expire_o = step_i & at_term & ~clear_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (step_i) begin
      if (at_term) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  p_base_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TERM);
  p_base_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             soft_en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= 1'b0;
    else if (wr_i) en_q <= wdata_i[0];
  end

  assign soft_en_o = en_q;
  assign rdata_o   = {{(REG_W-1){1'b0}}, en_q};

  p_reg_write_r10: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (rdata_o[0] == $past(wdata_i[0])));
  p_reg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/wdt_sleep_top.sv
module wdt_sleep_top
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_i,
  input  logic                cfg_en_i,
  input  logic [PS_SEL_W-1:0] cfg_ps_sel_i,
  input  logic                clr_i,
  input  logic                sleep_i,
  input  logic                core_asleep_i,
  input  logic                bus_wr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                rst_req_o,
  output logic                wake_o,
  output logic                to_n_o
);
  logic      tick;
  logic      step;
  logic      expire;
  logic      soft_en;
  logic      enabled;
  logic      clear;
  exp_kind_e kind;

  assign enabled = cfg_en_i | soft_en;
  assign clear   = clr_i | sleep_i | ~enabled;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .osc_i(osc_i), .tick_o(tick)
  );

  wdt_postscaler i_ps (
    .clk(clk), .rst(rst), .clear_i(clear), .tick_i(tick),
    .sel_i(cfg_ps_sel_i), .step_o(step)
  );

  wdt_base_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_base (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(step), .expire_o(expire)
  );

  wdt_ctrl_reg i_ctrl (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .soft_en_o(soft_en)
  );

  always_comb begin
    if (!expire)            kind = EXP_NONE;
    else if (core_asleep_i) kind = EXP_WAKE;
    else                    kind = EXP_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o <= 1'b0;
      wake_o    <= 1'b0;
      to_n_o    <= 1'b1;
    end else begin
      rst_req_o <= (kind == EXP_RESET);
      wake_o    <= (kind == EXP_WAKE);
      if (kind != EXP_NONE) to_n_o <= 1'b0;
      else if (clr_i)       to_n_o <= 1'b1;
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rst_req_o && wake_o));
  p_rst_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
  p_to_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o || wake_o) |-> !to_n_o);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en_i && !soft_en) |=> !(rst_req_o || wake_o));
  p_sleep_keeps_to_r7: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !clr_i) |=> $stable(to_n_o));
endmodule

// File: tb/test_wdt_sleep_top.sv
module test_wdt_sleep_top;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_i = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic [2:0] cfg_ps_sel_i = 3'd0;
  logic       clr_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       core_asleep_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       rst_req_o, wake_o, to_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_sleep_top #(.TIMEOUT_TICKS(N)) i_wdt_sleep_top (
    .clk(clk), .rst(rst), .osc_i(osc_i), .cfg_en_i(cfg_en_i),
    .cfg_ps_sel_i(cfg_ps_sel_i), .clr_i(clr_i), .sleep_i(sleep_i),
    .core_asleep_i(core_asleep_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .rst_req_o(rst_req_o), .wake_o(wake_o), .to_n_o(to_n_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic one_tick(output bit r, output bit w, output bit late);
    osc_i = 1'b1;
    repeat (2) @(negedge clk);
    osc_i = 1'b0;
    @(negedge clk);
    r = rst_req_o;
    w = wake_o;
    @(negedge clk);
    late = rst_req_o | wake_o;
  endtask

  task automatic run_to_expiry(input int limit, output int idx,
                               output bit r, output bit w);
    bit a, b, l;
    idx = 0; r = 0; w = 0;
    for (int i = 1; i <= limit; i++) begin
      one_tick(a, b, l);
      if (l) chk(1'b0, "R3", "pulse longer than one cycle", 1, 0);
      if (a || b) begin
        idx = i; r = a; w = b;
        return;
      end
    end
  endtask

  task automatic strobe_clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_sleep();
    sleep_i = 1'b1;
    @(negedge clk);
    sleep_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_wr_i = 1'b1;
    bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int idx;
    bit r, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rst_req_o == 0, "R1", "rst_req_o after reset", rst_req_o, 0);
    chk(wake_o == 0, "R1", "wake_o after reset", wake_o, 0);
    chk(to_n_o == 1, "R1", "to_n_o after reset", to_n_o, 1);
    chk(bus_rdata_o == 8'h00, "R1", "rdata after reset", bus_rdata_o, 0);

    // R9 disabled timer never expires
    run_to_expiry(3 * 128 * N, idx, r, w);
    chk(idx == 0, "R9", "expiry while disabled", idx, 0);
    chk(to_n_o == 1, "R9", "to_n_o while disabled", to_n_o, 1);

    // R2 / R3 / R8 sweep over every select, forced on by configuration
    cfg_en_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      cfg_ps_sel_i = 3'(s);
      strobe_clr();
      chk(to_n_o == 1, "R5", "to_n_o after clear", to_n_o, 1);
      run_to_expiry(2 * 128 * N, idx, r, w);
      chk(idx == (1 << s) * N, "R2", "edges to expiry", idx, (1 << s) * N);
      chk(r == 1 && w == 0, "R3", "reset kind while running", {r, w}, 2);
      chk(to_n_o == 0, "R5", "to_n_o after expiry", to_n_o, 0);
      if (s < 3) begin
        run_to_expiry(2 * 128 * N, idx, r, w);
        chk(idx == (1 << s) * N, "R2", "periodic expiry", idx, (1 << s) * N);
      end
    end

    // R6 clear mid-postscaler restarts full period, ratio kept
    cfg_ps_sel_i = 3'd2;
    strobe_clr();
    run_to_expiry(3, idx, r, w);
    strobe_clr();
    run_to_expiry(4 * N + 4, idx, r, w);
    chk(idx == 4 * N, "R6", "edges after mid clear", idx, 4 * N);

    // R4 / R7 sleep entry clears counters, expiry wakes
    cfg_ps_sel_i = 3'd1;
    strobe_clr();
    run_to_expiry(2 * N - 1, idx, r, w);
    chk(idx == 0, "R6", "no expiry before period", idx, 0);
    core_asleep_i = 1'b1;
    strobe_sleep();
    run_to_expiry(4 * N, idx, r, w);
    chk(idx == 2 * N, "R7", "edges after sleep entry", idx, 2 * N);
    chk(w == 1 && r == 0, "R4", "wake kind while asleep", {r, w}, 1);
    chk(to_n_o == 0, "R5", "to_n_o after wake", to_n_o, 0);
    strobe_sleep();
    chk(to_n_o == 0, "R7", "sleep strobe leaves to_n_o", to_n_o, 0);
    core_asleep_i = 1'b0;
    strobe_clr();
    chk(to_n_o == 1, "R5", "clear restores to_n_o", to_n_o, 1);

    // R10 register bits
    bus_write(8'hFE);
    chk(bus_rdata_o == 8'h00, "R10", "write FE reads", bus_rdata_o, 0);
    bus_write(8'hFF);
    chk(bus_rdata_o == 8'h01, "R10", "write FF reads", bus_rdata_o, 1);

    // R8 config on with soft bit 0 still runs
    bus_write(8'h00);
    cfg_ps_sel_i = 3'd0;
    strobe_clr();
    run_to_expiry(2 * N, idx, r, w);
    chk(idx == N, "R8", "runs with soft bit clear", idx, N);

    // R9 soft enable controls when config is off
    cfg_en_i = 1'b0;
    strobe_clr();
    run_to_expiry(3 * N, idx, r, w);
    chk(idx == 0, "R9", "soft off no expiry", idx, 0);
    bus_write(8'h01);
    run_to_expiry(3 * N, idx, r, w);
    chk(idx == N, "R9", "soft on expiry", idx, N);

    // R11 exact latency: pulse absent one clock earlier
    strobe_clr();
    for (int i = 1; i < N; i++) one_tick(r, w, r);
    osc_i = 1'b1;
    repeat (2) @(negedge clk);
    osc_i = 1'b0;
    chk(rst_req_o == 0, "R11", "pulse not early", rst_req_o, 0);
    @(negedge clk);
    chk(rst_req_o == 1, "R11", "pulse on third edge", rst_req_o, 1);
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule